// File: doc/BRIEF.md
# SMBus Host Register Front End

This block is the software-facing register layer that sits in front of an SMBus host engine. Software programs a control byte that holds the command code, the interrupt enable, the packet-error-check enable and the last-byte flag. A write that sets the start bit launches the command. The block raises a busy flag until the engine reports the end of the command. It then latches either a completion flag or a device-error flag. Software clears both flags by writing ones to them. An interrupt line follows the flags and is gated by the enable.

The block also holds the check byte register and a 32-entry byte buffer for block transfers. The buffer is walked by a single pointer. Software accesses and engine byte strobes advance the pointer, and any read of the control register sets it back to zero. A second-level timeout input forces the last-byte control on and holds it there. Bit timing, CRC generation and system-management interrupt routing belong to other blocks.

Register map, by offset. 0: status. 2: control. 3: check byte. 7: block data. Other offsets read as zero and ignore writes. Every read returns its value on `reg_rdata` in the single cycle after `reg_rd` is sampled.

Top module: `smb_host_regs`

## Requirements
- R1: After a synchronous reset, the status, control and check-byte registers read 00h. `irq` and `eng_start` are 0, and the buffer pointer is 0.
- R2: Control bits are: bit0 interrupt enable, bit1 reserved (reads 0), bits[4:2] command code, bit5 last byte, bit6 start, bit7 check-byte enable. A write with bit6=1 while idle does three things: it pulses `eng_start` high for exactly one cycle, starting the cycle after the write; it sets busy in that same cycle; and it drives the new command and enables on `eng_cmd` and `eng_pec_en`. Bit6 always reads 0.
- R3: Status bits are: bit0 busy, bit1 done, bit2 device error. When `eng_done` is sampled while busy, busy clears. Done sets if `eng_err` is zero; otherwise device error sets. The three `eng_err` bits are the illegal-command, unclaimed-cycle and device-timeout causes. `eng_done` while idle changes nothing.
- R4: Done sets on a successful end even when the interrupt enable is 0, and `irq` stays 0 in that case.
- R5: When idle, writing 1 to status bit1 clears done and writing 1 to status bit2 clears device error. Writing 0 leaves a flag unchanged. `irq` falls one cycle after the clear.
- R6: `irq` equals the interrupt enable AND (done OR device error), taken from the previous cycle.
- R7: While busy, writes to status and to the check byte are ignored. A control write changes only bit5, so a second start launches nothing.
- R8: Any read of offset 2 sets the buffer pointer to 0.
- R9: A write to offset 7 stores the byte at the pointer. A read of offset 7 returns the byte at the pointer. Each access advances the pointer, and the pointer wraps from 31 to 0. An `eng_rx_valid` strobe stores `eng_rx_data` at the pointer and advances it; this is accepted even while busy.
- R10: While `tmo_flag` is 1, the last-byte bit is set every cycle and software cannot clear it. After `tmo_flag` falls, a write can clear it.
- R11: The check-byte register is read/write at offset 3 and drives `eng_pec_tx`. An `eng_pec_rx_valid` strobe loads `eng_pec_rx` into it only when the check-byte enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after the read |
| irq | output | 1 | Interrupt request |
| eng_start | output | 1 | One-cycle launch pulse to the engine |
| eng_cmd | output | 3 | Command code |
| eng_pec_en | output | 1 | Check-byte phase enable |
| eng_last_byte | output | 1 | NACK the next received byte |
| eng_pec_tx | output | 8 | Check byte to transmit |
| eng_done | input | 1 | Command end strobe |
| eng_err | input | 3 | Error causes, valid with eng_done |
| eng_rx_valid | input | 1 | Received byte strobe |
| eng_rx_data | input | 8 | Received byte |
| eng_pec_rx_valid | input | 1 | Received check byte strobe |
| eng_pec_rx | input | 8 | Received check byte |
| tmo_flag | input | 1 | Second-level timeout status |

## Verification
Most state errors in this block show up at the ports within one or two cycles. A stuck or lost busy flag shows as a missing or repeated `eng_start` pulse, and as a wrong status readback on the next read. A flag that latches on the wrong condition changes `irq` one cycle later, provided the enable is set. A pointer that drifts is the slowest fault to appear. It is visible only when block data is read back, so reads are placed after every pointer reset, every engine byte strobe and the wrap point.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;
  localparam int REG_W = 8;
  localparam int CMD_W = 3;
  localparam int ERR_W = 3;

  // register offsets
  localparam int OFS_STAT = 0;
  localparam int OFS_CTRL = 2;
  localparam int OFS_PEC  = 3;
  localparam int OFS_BLK  = 7;

  // control bit positions
  localparam int CB_IEN   = 0;
  localparam int CB_CMD   = 2;
  localparam int CB_LAST  = 5;
  localparam int CB_START = 6;
  localparam int CB_PEC   = 7;

  // status bit positions
  localparam int SB_BUSY = 0;
  localparam int SB_DONE = 1;
  localparam int SB_ERR  = 2;

  typedef struct packed {
    logic             pec_en;
    logic             last;
    logic [CMD_W-1:0] cmd;
    logic             ien;
  } ctrl_t;
endpackage

// File: rtl/smb_ctrl_reg.sv
module smb_ctrl_reg
  import smb_host_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_hit,
  input  logic             w_ien,
  input  logic [CMD_W-1:0] w_cmd,
  input  logic             w_last,
  input  logic             w_start,
  input  logic             w_pec,
  input  logic             busy,
  input  logic             tmo_flag,
  output ctrl_t            ctrl,
  output logic             go,
  output logic             launch
);
  // a start request only counts when no command is running
  assign go = wr_hit & ~busy & w_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      launch <= 1'b0;
    end else begin
      launch <= go;
      if (wr_hit) begin
        if (!busy) begin
          ctrl.ien    <= w_ien;
          ctrl.cmd    <= w_cmd;
          ctrl.pec_en <= w_pec;
          ctrl.last   <= w_last;
        end else begin
          ctrl.last   <= w_last;
        end
      end
      if (tmo_flag) ctrl.last <= 1'b1;
    end
  end
endmodule

// File: rtl/smb_stat_reg.sv
module smb_stat_reg
  import smb_host_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic             eng_done,
  input  logic [ERR_W-1:0] eng_err,
  input  logic             clr_hit,
  input  logic             clr_done,
  input  logic             clr_err,
  input  logic             ien,
  output logic             busy,
  output logic             done_flag,
  output logic             err_flag,
  output logic             irq
);
  logic fin;
  logic fin_bad;

  assign fin     = eng_done & busy;
  assign fin_bad = |eng_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done_flag <= 1'b0;
      err_flag  <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (go)       busy <= 1'b1;
      else if (fin) busy <= 1'b0;

      if (fin && !fin_bad)          done_flag <= 1'b1;
      else if (clr_hit && clr_done) done_flag <= 1'b0;

      if (fin && fin_bad)          err_flag <= 1'b1;
      else if (clr_hit && clr_err) err_flag <= 1'b0;

      irq <= ien & (done_flag | err_flag);
    end
  end
endmodule

// File: rtl/smb_blk_buf.sv
module smb_blk_buf #(
  parameter int DEPTH = 32,
  parameter int W     = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ptr_clr,
  input  logic             sw_wr,
  input  logic             sw_rd,
  input  logic [W-1:0]     sw_wdata,
  input  logic             rx_valid,
  input  logic [W-1:0]     rx_data,
  output logic [W-1:0]     rdata,
  output logic [PTR_W-1:0] ptr
);
  logic [W-1:0] mem [DEPTH];
  logic         we;
  logic [W-1:0] wd;
  logic         step;

  assign we   = rx_valid | sw_wr;
  assign wd   = rx_valid ? rx_data : sw_wdata;
  assign step = rx_valid | sw_wr | sw_rd;

  // single-port, read-first: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[ptr] <= wd;
    rdata <= mem[ptr];
  end

  always_ff @(posedge clk) begin
    if (rst)          ptr <= '0;
    else if (ptr_clr) ptr <= '0;
    else if (step)    ptr <= (ptr == PTR_W'(DEPTH-1)) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
  import smb_host_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int BUF_DEPTH = 32,
  localparam int PTR_W = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq,
  output logic              eng_start,
  output logic [2:0]        eng_cmd,
  output logic              eng_pec_en,
  output logic              eng_last_byte,
  output logic [7:0]        eng_pec_tx,
  input  logic              eng_done,
  input  logic [2:0]        eng_err,
  input  logic              eng_rx_valid,
  input  logic [7:0]        eng_rx_data,
  input  logic              eng_pec_rx_valid,
  input  logic [7:0]        eng_pec_rx,
  input  logic              tmo_flag
);
  logic sel_stat, sel_ctrl, sel_pec, sel_blk;
  assign sel_stat = (reg_addr == ADDR_W'(OFS_STAT));
  assign sel_ctrl = (reg_addr == ADDR_W'(OFS_CTRL));
  assign sel_pec  = (reg_addr == ADDR_W'(OFS_PEC));
  assign sel_blk  = (reg_addr == ADDR_W'(OFS_BLK));

  ctrl_t            ctrl;
  logic             go;
  logic             busy, done_flag, err_flag, irq_en;
  logic [7:0]       pec_q;
  logic [7:0]       buf_rdata;
  logic [PTR_W-1:0] blk_ptr;

  assign irq_en = ctrl.ien;

  smb_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr_hit   (reg_wr & sel_ctrl),
    .w_ien    (reg_wdata[CB_IEN]),
    .w_cmd    (reg_wdata[CB_CMD +: CMD_W]),
    .w_last   (reg_wdata[CB_LAST]),
    .w_start  (reg_wdata[CB_START]),
    .w_pec    (reg_wdata[CB_PEC]),
    .busy     (busy),
    .tmo_flag (tmo_flag),
    .ctrl     (ctrl),
    .go       (go),
    .launch   (eng_start)
  );

  smb_stat_reg u_stat (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .eng_done  (eng_done),
    .eng_err   (eng_err),
    .clr_hit   (reg_wr & sel_stat & ~busy),
    .clr_done  (reg_wdata[SB_DONE]),
    .clr_err   (reg_wdata[SB_ERR]),
    .ien       (ctrl.ien),
    .busy      (busy),
    .done_flag (done_flag),
    .err_flag  (err_flag),
    .irq       (irq)
  );

  smb_blk_buf #(.DEPTH(BUF_DEPTH), .W(8)) u_buf (
    .clk      (clk),
    .rst      (rst),
    .ptr_clr  (reg_rd & sel_ctrl),
    .sw_wr    (reg_wr & sel_blk),
    .sw_rd    (reg_rd & sel_blk),
    .sw_wdata (reg_wdata),
    .rx_valid (eng_rx_valid),
    .rx_data  (eng_rx_data),
    .rdata    (buf_rdata),
    .ptr      (blk_ptr)
  );

  // check byte register: engine load wins over software
  always_ff @(posedge clk) begin
    if (rst)                                   pec_q <= '0;
    else if (eng_pec_rx_valid && ctrl.pec_en)  pec_q <= eng_pec_rx;
    else if (reg_wr && sel_pec && !busy)       pec_q <= reg_wdata;
  end

  // read path
  logic [7:0] rd_mux;
  logic [7:0] rd_val_q;
  logic       rd_buf_q;

  always_comb begin
    rd_mux = '0;
    if (sel_stat) begin
      rd_mux[SB_BUSY] = busy;
      rd_mux[SB_DONE] = done_flag;
      rd_mux[SB_ERR]  = err_flag;
    end else if (sel_ctrl) begin
      rd_mux[CB_IEN]            = ctrl.ien;
      rd_mux[CB_CMD +: CMD_W]   = ctrl.cmd;
      rd_mux[CB_LAST]           = ctrl.last;
      rd_mux[CB_PEC]            = ctrl.pec_en;
    end else if (sel_pec) begin
      rd_mux = pec_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_val_q <= '0;
      rd_buf_q <= 1'b0;
    end else if (reg_rd) begin
      rd_val_q <= rd_mux;
      rd_buf_q <= sel_blk;
    end
  end

  assign reg_rdata     = rd_buf_q ? buf_rdata : rd_val_q;
  assign eng_cmd       = ctrl.cmd;
  assign eng_pec_en    = ctrl.pec_en;
  assign eng_last_byte = ctrl.last;
  assign eng_pec_tx    = pec_q;
endmodule

// File: rtl/smb_host_regs_chk.sv
module smb_host_regs_chk #(
  parameter int ADDR_W = 3,
  parameter int PTR_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done_flag,
  input logic              err_flag,
  input logic              irq,
  input logic              irq_en,
  input logic              eng_start,
  input logic              eng_done,
  input logic              eng_last_byte,
  input logic              tmo_flag,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [PTR_W-1:0]  blk_ptr
);
  // R2
  launch_rises_busy_chk: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> $rose(busy));
  // R2
  launch_single_chk: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start);
  // R3
  done_needs_end_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_flag) |-> $past(busy) && $past(eng_done));
  // R3
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(eng_done));
  // R6
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(irq_en) && $past(done_flag || err_flag));
  // R10
  tmo_forces_last_chk: assert property (@(posedge clk) disable iff (rst)
    tmo_flag |=> eng_last_byte);
  // R8
  ptr_home_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == ADDR_W'(2)) |=> blk_ptr == '0);
endmodule

bind smb_host_regs smb_host_regs_chk #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) i_chk (
  .clk           (clk),
  .rst           (rst),
  .busy          (busy),
  .done_flag     (done_flag),
  .err_flag      (err_flag),
  .irq           (irq),
  .irq_en        (irq_en),
  .eng_start     (eng_start),
  .eng_done      (eng_done),
  .eng_last_byte (eng_last_byte),
  .tmo_flag      (tmo_flag),
  .reg_rd        (reg_rd),
  .reg_addr      (reg_addr),
  .blk_ptr       (blk_ptr)
);

// File: tb/test_smb_host_regs.sv
`timescale 1ns/1ps
module test_smb_host_regs;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq, eng_start, eng_pec_en, eng_last_byte;
  logic [2:0] eng_cmd;
  logic [7:0] eng_pec_tx;
  logic       eng_done = 1'b0;
  logic [2:0] eng_err = '0;
  logic       eng_rx_valid = 1'b0;
  logic [7:0] eng_rx_data = '0;
  logic       eng_pec_rx_valid = 1'b0;
  logic [7:0] eng_pec_rx = '0;
  logic       tmo_flag = 1'b0;

  always #2 clk = ~clk;

  smb_host_regs i_smb_host_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .eng_start(eng_start),
    .eng_cmd(eng_cmd), .eng_pec_en(eng_pec_en), .eng_last_byte(eng_last_byte),
    .eng_pec_tx(eng_pec_tx), .eng_done(eng_done), .eng_err(eng_err),
    .eng_rx_valid(eng_rx_valid), .eng_rx_data(eng_rx_data),
    .eng_pec_rx_valid(eng_pec_rx_valid), .eng_pec_rx(eng_pec_rx), .tmo_flag(tmo_flag)
  );

  int n_chk = 0, n_fail = 0;
  string cur_tag = "R1";

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit       m_on = 0;
  bit       m_busy, m_done, m_err, m_ien, m_lb, m_pecen, m_irq, m_start, m_rdv;
  int       m_cmd, m_pec, m_ptr, m_rexp;
  int       m_mem[32];
  bit       o_busy, o_done, o_err, o_ien, o_pecen;

  function automatic int m_read(int a);
    case (a)
      0: return (m_err << 2) | (m_done << 1) | m_busy;
      2: return (m_pecen << 7) | (m_lb << 5) | (m_cmd << 2) | m_ien;
      3: return m_pec;
      7: return m_mem[m_ptr];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_on = 1; m_busy = 0; m_done = 0; m_err = 0; m_ien = 0; m_lb = 0; m_pecen = 0;
      m_irq = 0; m_start = 0; m_rdv = 0; m_cmd = 0; m_pec = 0; m_ptr = 0;
    end else begin
      o_busy = m_busy; o_done = m_done; o_err = m_err; o_ien = m_ien; o_pecen = m_pecen;
      m_irq = o_ien && (o_done || o_err);
      m_start = 0;
      m_rdv = reg_rd;
      if (reg_rd) m_rexp = m_read(reg_addr);
      if (eng_done && o_busy) begin
        m_busy = 0;
        if (eng_err != 0) m_err = 1; else m_done = 1;
      end
      if (reg_wr) begin
        if (reg_addr == 0 && !o_busy) begin
          if (reg_wdata[1]) m_done = 0;
          if (reg_wdata[2]) m_err = 0;
        end
        if (reg_addr == 2) begin
          m_lb = reg_wdata[5];
          if (!o_busy) begin
            m_ien = reg_wdata[0]; m_cmd = reg_wdata[4:2]; m_pecen = reg_wdata[7];
            if (reg_wdata[6]) begin m_busy = 1; m_start = 1; end
          end
        end
        if (reg_addr == 3 && !o_busy) m_pec = reg_wdata;
      end
      if (eng_pec_rx_valid && o_pecen) m_pec = eng_pec_rx;
      if (tmo_flag) m_lb = 1;
      if (eng_rx_valid) m_mem[m_ptr] = eng_rx_data;
      else if (reg_wr && reg_addr == 7) m_mem[m_ptr] = reg_wdata;
      if (reg_rd && reg_addr == 2) m_ptr = 0;
      else if (eng_rx_valid || (reg_wr && reg_addr == 7) || (reg_rd && reg_addr == 7))
        m_ptr = (m_ptr + 1) % 32;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (m_on && !rst) begin
      chk("R6 irq", irq, m_irq);
      chk("R2 eng_start", eng_start, m_start);
      chk("R2 eng_cmd", eng_cmd, m_cmd);
      chk("R2 eng_pec_en", eng_pec_en, m_pecen);
      chk("R10 eng_last_byte", eng_last_byte, m_lb);
      chk("R11 eng_pec_tx", eng_pec_tx, m_pec);
      if (m_rdv) chk({cur_tag, " model rdata"}, reg_rdata, m_rexp);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(int a, int d);
    reg_wr = 1; reg_addr = a[2:0]; reg_wdata = d[7:0];
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic exp_rd(int a, int exp, string tag);
    cur_tag = tag;
    reg_rd = 1; reg_addr = a[2:0];
    @(negedge clk);
    reg_rd = 0;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic pulse_done(int e);
    eng_done = 1; eng_err = e[2:0];
    @(negedge clk);
    eng_done = 0; eng_err = 0;
  endtask

  task automatic rx_byte(int d);
    eng_rx_valid = 1; eng_rx_data = d[7:0];
    @(negedge clk);
    eng_rx_valid = 0;
  endtask

  task automatic pec_in(int d);
    eng_pec_rx_valid = 1; eng_pec_rx = d[7:0];
    @(negedge clk);
    eng_pec_rx_valid = 0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset values
    exp_rd(0, 8'h00, "R1");
    exp_rd(2, 8'h00, "R1");
    exp_rd(3, 8'h00, "R1");
    chk("R1 irq", irq, 0);
    // R9 fill buffer; pointer wraps back to 0
    for (int i = 0; i < 32; i++) wr(7, (i * 7 + 3) & 8'hFF);
    exp_rd(7, 3, "R9");
    exp_rd(7, 10, "R9");
    exp_rd(2, 8'h00, "R8");
    exp_rd(7, 3, "R8");
    exp_rd(2, 8'h00, "R8");
    for (int i = 0; i < 33; i++) exp_rd(7, ((i % 32) * 7 + 3) & 8'hFF, "R9");
    // R11 software access to the check byte
    wr(3, 8'hA5);
    exp_rd(3, 8'hA5, "R11");
    // R2 setup then launch
    wr(2, 8'h94);
    exp_rd(2, 8'h94, "R2");
    wr(2, 8'hD4);
    exp_rd(0, 8'h01, "R2");
    exp_rd(2, 8'h94, "R2");
    // R7 writes while busy
    wr(2, 8'h61);
    exp_rd(2, 8'hB4, "R7");
    wr(3, 8'h11);
    exp_rd(3, 8'hA5, "R7");
    wr(0, 8'h06);
    exp_rd(0, 8'h01, "R7");
    // R9 engine bytes (pointer at 0 after control read)
    exp_rd(2, 8'hB4, "R8");
    rx_byte(8'hC1);
    rx_byte(8'hC2);
    pec_in(8'h5E);
    // R4 success with interrupt disabled
    pulse_done(0);
    @(negedge clk);
    exp_rd(0, 8'h02, "R4");
    chk("R4 irq", irq, 0);
    exp_rd(2, 8'hB4, "R8");
    exp_rd(7, 8'hC1, "R9");
    exp_rd(7, 8'hC2, "R9");
    exp_rd(3, 8'h5E, "R11");
    // R6 enable interrupt
    wr(2, 8'h01);
    @(negedge clk);
    chk("R6 irq", irq, 1);
    // R5 clear done
    wr(0, 8'h02);
    @(negedge clk);
    chk("R5 irq", irq, 0);
    exp_rd(0, 8'h00, "R5");
    // R3 error termination
    wr(2, 8'h49);
    pulse_done(3'b010);
    @(negedge clk);
    exp_rd(0, 8'h04, "R3");
    chk("R3 irq", irq, 1);
    wr(0, 8'h04);
    exp_rd(0, 8'h00, "R5");
    // R3 end strobe while idle
    pulse_done(0);
    exp_rd(0, 8'h00, "R3");
    // R10 timeout lock
    tmo_flag = 1;
    @(negedge clk);
    wr(2, 8'h09);
    exp_rd(2, 8'h29, "R10");
    tmo_flag = 0;
    wr(2, 8'h09);
    exp_rd(2, 8'h09, "R10");
    // R11 engine check byte ignored when disabled
    pec_in(8'h77);
    exp_rd(3, 8'h5E, "R11");
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule